// File: doc/BRIEF.md
# Watchdog Interval Timer

This block is an 8-bit up-counter with a control/status byte. It runs either as a periodic interval timer that raises an interrupt request, or as a watchdog that asks the system for a reset when the count wraps. Software reaches both the counter and the control/status byte through a small register port. Every access completes in the cycle it is presented. There is no back-pressure: a strobe is always accepted. A write is honoured only if the upper byte of its 16-bit data word carries the key that belongs to the addressed register.

The counter steps on a prescaled clock enable. The three clock-select bits pick one of eight enable inputs from an external divider. The overflow flag is sticky. Software clears it by first reading the control/status byte while the flag is set, and then writing 0 to the flag bit. A software-standby input drops the mode, enable and flag bits at once, but keeps the clock selection.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control/status byte reads 0x18, the counter reads 0x00, and `ovf_o`, `irq_o` and `rst_req_o` are low.
- R2: Control/status bits 4 and 3 always read as 1, and writes to them have no effect. The byte reads as {flag[7], mode[6], enable[5], 1[4], 1[3], clksel[2:0]}.
- R3: While enable (bit 5) is 1, the counter adds one on every cycle in which `tick_i[clksel]` is high. While enable is 0, it holds its value.
- R4: When the counter steps from 0xFF to 0x00, the flag (bit 7, mirrored on `ovf_o`) is set.
- R5: A write of 0 to bit 7 clears the flag only if an earlier read of the control/status byte returned the flag as 1. Writing 1 to bit 7 never sets the flag, and a clear attempt with no such read leaves the flag set.
- R6: If an overflow and a valid clear arrive in the same cycle, the flag stays set. That clear uses up the earlier read, so a further clear needs a new read that sees the flag set.
- R7: When mode (bit 6) is 0, `irq_o` is high exactly while the flag is set.
- R8: When mode is 1, an overflow drives `rst_req_o` high for exactly the one cycle after the overflowing edge, and `irq_o` stays low.
- R9: While `standby_i` is high, bits 7, 6 and 5 are forced to 0, bits 2 to 0 keep their value, and control/status writes are ignored.
- R10: A write to address 0 (control/status) takes effect only when data[15:8] = 0xA5. A write to address 1 (counter) takes effect only when data[15:8] = 0x5A. Writes with any other key change nothing.
- R11: A valid counter write loads data[7:0] and takes priority over a same-cycle increment, so that cycle cannot cause an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Software-standby indication |
| tick_i | input | 8 | Prescaled clock enables, selected by clksel |
| bus_sel_i | input | 1 | Access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata_i | input | 16 | Key in [15:8], data in [7:0] |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interval interrupt request |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The counting path is driven once for each clock-select value with an irregular tick pattern. The expected count is the number of cycles in which the selected bit was high, so a wrong select or a missed step shows up as a different count. Every possible key byte is swept against both addresses, which separates the one accepted key from the 255 rejected ones and catches any mix-up between the two keys. The flag is then taken through overflow, clears without a prior read, clears with a prior read, a clear in the same cycle as an overflow, and standby. Each of these cases separates the set-wins and read-arming rules from simpler clearing schemes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_SRC = 8;
  localparam logic [7:0]  KEY_CSR = 8'hA5;
  localparam logic [7:0]  KEY_CNT = 8'h5A;

  typedef enum logic {
    ADDR_CSR = 1'b0,
    ADDR_CNT = 1'b1
  } wdt_addr_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SEL_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               en_i,
  output logic               inc_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] & (sel_i == SEL_W'(g));
  end

  assign inc_o = en_i & (|hit);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // a load wins over a step, so a loading cycle never wraps
  assign ovf_o = inc_i & ~wr_i & (cnt_q == CNT_MAX);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !wr_i) |=> $stable(cnt_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i))); // R11
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             clr_req_i,
  input  logic             mode_i,
  input  logic             tme_i,
  input  logic [SEL_W-1:0] cks_i,
  input  logic             ovf_evt_i,
  output logic             flag_o,
  output logic             mode_o,
  output logic             tme_o,
  output logic [SEL_W-1:0] cks_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic             flag_q, mode_q, tme_q, armed_q, rst_req_q;
  logic [SEL_W-1:0] cks_q;
  logic             wr_ok, clr_try;

  assign wr_ok   = wr_i & ~standby_i;
  assign clr_try = wr_ok & clr_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      mode_q  <= 1'b0;
      tme_q   <= 1'b0;
      armed_q <= 1'b0;
      cks_q   <= '0;
    end else if (standby_i) begin
      flag_q  <= 1'b0;
      mode_q  <= 1'b0;
      tme_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        mode_q <= mode_i;
        tme_q  <= tme_i;
        cks_q  <= cks_i;
      end
      if (ovf_evt_i)                flag_q <= 1'b1;
      else if (clr_try && armed_q)  flag_q <= 1'b0;
      if (clr_try)                  armed_q <= 1'b0;
      else if (rd_i && flag_q)      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= ovf_evt_i & mode_q & ~standby_i;
  end

  assign flag_o    = flag_q;
  assign mode_o    = mode_q;
  assign tme_o     = tme_q;
  assign cks_o     = cks_q;
  assign irq_o     = flag_q & ~mode_q;
  assign rst_req_o = rst_req_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_i && !standby_i) |=> flag_q); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q && !standby_i) |=> flag_q); // R5
  AST_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (!flag_q && !mode_q && !tme_q)); // R9
  AST_STBY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> $stable(cks_q)); // R9
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q); // R8
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = DATA_W,
  parameter int unsigned SRC_N    = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic [SRC_N-1:0]  tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int unsigned SEL_W = $clog2(SRC_N);

  logic             rd_csr, wr_csr, wr_cnt, key_csr_ok, key_cnt_ok;
  logic             inc, ovf_evt, flag, mode, tme;
  logic [SEL_W-1:0] cks;
  logic [CNT_W-1:0] cnt;

  assign key_csr_ok = (bus_wdata_i[15:8] == KEY_CSR);
  assign key_cnt_ok = (bus_wdata_i[15:8] == KEY_CNT);
  assign rd_csr = bus_sel_i & ~bus_wr_i & (bus_addr_i == ADDR_CSR);
  assign wr_csr = bus_sel_i &  bus_wr_i & (bus_addr_i == ADDR_CSR) & key_csr_ok;
  assign wr_cnt = bus_sel_i &  bus_wr_i & (bus_addr_i == ADDR_CNT) & key_cnt_ok;

  wdt_tick_sel #(.NUM_SRC(SRC_N), .SEL_W(SEL_W)) u_sel (
    .tick_i (tick_i),
    .sel_i  (cks),
    .en_i   (tme),
    .inc_o  (inc)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (inc),
    .wr_i    (wr_cnt),
    .wdata_i (bus_wdata_i[CNT_W-1:0]),
    .cnt_o   (cnt),
    .ovf_o   (ovf_evt)
  );

  wdt_csr #(.SEL_W(SEL_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .rd_i      (rd_csr),
    .wr_i      (wr_csr),
    .clr_req_i (~bus_wdata_i[7]),
    .mode_i    (bus_wdata_i[6]),
    .tme_i     (bus_wdata_i[5]),
    .cks_i     (bus_wdata_i[SEL_W-1:0]),
    .ovf_evt_i (ovf_evt),
    .flag_o    (flag),
    .mode_o    (mode),
    .tme_o     (tme),
    .cks_o     (cks),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    if (bus_addr_i == ADDR_CNT) bus_rdata_o = 8'(cnt);
    else                        bus_rdata_o = {flag, mode, tme, 2'b11, cks};
  end

  assign ovf_o = flag;

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i && !bus_addr_i && !key_csr_ok && !standby_i)
    |=> ($stable(mode) && $stable(tme) && $stable(cks))); // R10
  AST_WDOG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !irq_o); // R8
endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  logic        clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
  logic [7:0]  tick = 8'h00;
  logic        sel = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [7:0]  rdata;
  logic        ovf, irq, rreq;
  int          nvec = 0, nerr = 0;

  always #4 clk = ~clk;

  wdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .tick_i(tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ovf_o(ovf), .irq_o(irq), .rst_req_o(rreq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic run_ticks(input logic [7:0] p, input int n);
    @(negedge clk); tick = p;
    repeat (n) @(negedge clk);
    tick = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] d, p;
    int cexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(1'b0, d); chk("R1 csr", d, 8'h18);
    bus_read(1'b1, d); chk("R1 cnt", d, 8'h00);
    chk("R1 outs", {ovf, irq, rreq}, 3'b000);

    // R2 reserved bits
    bus_write(1'b0, 16'hA507); bus_read(1'b0, d); chk("R2", d, 8'h1F);
    bus_write(1'b0, 16'hA500); bus_read(1'b0, d); chk("R2", d, 8'h18);

    // R10 key sweeps on both addresses
    for (int k = 0; k < 256; k++) begin
      bus_write(1'b0, {8'(k), 8'h03});
      bus_read(1'b0, d);
      chk("R10 csr key", d, (k == 8'hA5) ? 8'h1B : 8'h18);
      if (k == 8'hA5) bus_write(1'b0, 16'hA500);
    end
    for (int k = 0; k < 256; k++) begin
      bus_write(1'b1, {8'(k), 8'h3C});
      bus_read(1'b1, d);
      chk("R10 cnt key", d, (k == 8'h5A) ? 8'h3C : 8'h00);
      if (k == 8'h5A) bus_write(1'b1, 16'h5A00);
    end

    // R3 clock-select sweep and hold
    for (int s = 0; s < 8; s++) begin
      cexp = 0;
      bus_write(1'b1, 16'h5A00);
      bus_write(1'b0, {8'hA5, 8'(8'h20 | s)});
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        p = 8'((k * 37) ^ (s * 91) ^ (k >> 1));
        tick = p;
        if (p[s]) cexp++;
      end
      @(negedge clk); tick = 8'h00;
      bus_write(1'b0, {8'hA5, 8'(s)});
      bus_read(1'b1, d); chk("R3 count", d, 8'(cexp));
      run_ticks(8'hFF, 4);
      bus_read(1'b1, d); chk("R3 hold", d, 8'(cexp));
    end

    // R4 R7 overflow in interval mode
    bus_write(1'b1, 16'h5AFE);
    bus_write(1'b0, 16'hA520);
    run_ticks(8'h01, 2);
    chk("R4 flag", ovf, 1'b1);
    chk("R7 irq", irq, 1'b1);
    chk("R8 no rst in interval", rreq, 1'b0);
    bus_read(1'b1, d); chk("R4 wrap", d, 8'h00);

    // R5 clearing rules
    bus_write(1'b0, 16'hA520); chk("R5 no read", ovf, 1'b1);
    bus_write(1'b0, 16'hA5A0); chk("R5 write one", ovf, 1'b1);
    bus_read(1'b0, d); chk("R5 read", d, 8'hB8);
    bus_write(1'b0, 16'h5A20); chk("R10 bad key clear", ovf, 1'b1);
    bus_write(1'b0, 16'hA520); chk("R5 clear", ovf, 1'b0);
    chk("R7 irq low", irq, 1'b0);
    bus_write(1'b0, 16'hA5A0); chk("R5 no set", ovf, 1'b0);

    // R6 set wins over clear
    bus_write(1'b1, 16'h5AFF);
    run_ticks(8'h01, 1);
    chk("R6 setup", ovf, 1'b1);
    bus_write(1'b1, 16'h5AFF);
    bus_read(1'b0, d);
    @(negedge clk); tick = 8'h01; sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 16'hA520;
    @(negedge clk); tick = 8'h00; sel = 1'b0; wr = 1'b0;
    chk("R6 set wins", ovf, 1'b1);
    bus_write(1'b0, 16'hA520); chk("R6 rearm needed", ovf, 1'b1);
    bus_read(1'b0, d);
    bus_write(1'b0, 16'hA520); chk("R6 clear", ovf, 1'b0);

    // R8 watchdog pulse
    bus_write(1'b0, 16'hA540);
    bus_write(1'b1, 16'h5AFF);
    bus_write(1'b0, 16'hA560);
    @(negedge clk); tick = 8'h01;
    @(posedge clk); #1;
    chk("R8 pulse", rreq, 1'b1);
    chk("R8 irq low", irq, 1'b0);
    @(negedge clk); tick = 8'h00;
    @(posedge clk); #1;
    chk("R8 one cycle", rreq, 1'b0);
    bus_read(1'b0, d); chk("R8 flag", d, 8'hF8);
    bus_write(1'b0, 16'hA520); chk("R8 clear", ovf, 1'b0);

    // R11 load beats step
    bus_write(1'b1, 16'h5AFF);
    @(negedge clk); tick = 8'h01; sel = 1'b1; wr = 1'b1; addr = 1'b1; wdata = 16'h5A10;
    @(negedge clk); tick = 8'h00; sel = 1'b0; wr = 1'b0;
    bus_read(1'b1, d); chk("R11 load", d, 8'h10);
    chk("R11 no ovf", ovf, 1'b0);

    // R9 standby
    bus_write(1'b0, 16'hA565);
    bus_write(1'b1, 16'h5AFF);
    run_ticks(8'h20, 1);
    chk("R9 setup", ovf, 1'b1);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 16'hA527;
    @(negedge clk); sel = 1'b0; wr = 1'b0; standby = 1'b0;
    bus_read(1'b0, d); chk("R9 standby", d, 8'h1D);
    chk("R9 flag", ovf, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule